// File: doc/BRIEF.md
# Circular-capable indirect address generator

This block forms the effective address for an indirect memory operand of a DSP datapath and works out the new value that the auxiliary register involved must take. Each request carries a 5-bit modify code, the auxiliary register's current value and index, an 8-bit unsigned displacement, two index registers, and two flags. One flag replaces the displacement with a step of one. The other flag defers the register update. A block-size register with a derived wrap mask is kept inside the block and is loaded through a write strobe.

The modify code has two fields. The upper two bits pick the step source and the lower three bits pick the operation. The operations cover offset without update, pre-modify with update, post-modify with update, and circular post-modify. Circular modify wraps only the bits under the mask, modulo the block size, and leaves the upper address bits untouched.

Results are registered one cycle after the request. An update appears either on the immediate writeback port or on the pending port, so a parallel second operand can still read the old register contents. Internally the request decodes into a source state (displacement, index 0, index 1 or none) and an operation state. The source names are SRC_DISP, SRC_IDX0, SRC_IDX1 and SRC_NONE. The operation names are OP_ADD_PEEK, OP_SUB_PEEK, OP_PRE_ADD, OP_PRE_SUB, OP_POST_ADD, OP_POST_SUB, OP_CIRC_ADD and OP_CIRC_SUB. The only held state is the block-size register and its mask. A write moves them from the old size to the new size at the clock edge.

Top module: `agen_indirect`

## Requirements
- R1: The source is decoded from mod_code[4:3]: 00 selects the displacement, 01 selects index 0, 10 selects index 1, and 11 selects no source. With source 00, unit_step=1 replaces the displacement by 1. The displacement is zero-extended.
- R2: Operations 0 (add) and 1 (subtract), taken from mod_code[2:0], give ea = ar_val ± step modulo 2^AW and request no writeback.
- R3: Operations 2 and 3 (pre-add and pre-subtract) give ea = new value = ar_val ± step and request a writeback.
- R4: Operations 4 and 5 (post-add and post-subtract) give ea = ar_val and a new value of ar_val ± step, with a writeback.
- R5: Operation 6 (circular add) computes t = (ar_val AND mask) + step. If t ≥ block size, block size is subtracted once.
- R6: Operation 7 (circular subtract) computes t = (ar_val AND mask) − step. If t is negative, block size is added once.
- R7: Circular operations give ea = ar_val and a new value of (ar_val AND NOT mask) OR (t AND mask), so the bits above the mask are kept.
- R8: The mask has ones from bit 0 up to and including the highest set bit of the block size. A write loads both the block size and the mask. The write affects only requests in later cycles. Reset clears both to zero.
- R9: Any code with mod_code[4:3]=11 gives ea = ar_val and requests no writeback.
- R10: With defer=1, an update appears on pend_en/pend_idx/pend_val and wb_en stays low. With defer=0, it appears on wb_en/wb_idx/wb_val and pend_en stays low. The index is ar_idx.
- R11: Outputs are registered and appear one cycle after op_valid. A cycle with op_valid=0 is followed by ea_valid, wb_en and pend_en all low. Reset drives every output to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| blk_we | input | 1 | Load strobe for the block-size register |
| blk_wdata | input | AW | New block size |
| op_valid | input | 1 | Request present |
| mod_code | input | 5 | Source field [4:3] and operation field [2:0] |
| unit_step | input | 1 | Use a step of one instead of the displacement |
| defer | input | 1 | Route the update to the pending port |
| ar_idx | input | RIDX_W | Index of the auxiliary register |
| ar_val | input | AW | Current auxiliary register value |
| disp | input | DISP_W | Unsigned displacement |
| idx0 | input | AW | Index register 0 |
| idx1 | input | AW | Index register 1 |
| ea_valid | output | 1 | Effective address valid |
| ea | output | AW | Effective address |
| wb_en | output | 1 | Immediate writeback strobe |
| wb_idx | output | RIDX_W | Immediate writeback target |
| wb_val | output | AW | Immediate writeback value |
| pend_en | output | 1 | Deferred writeback strobe |
| pend_idx | output | RIDX_W | Deferred writeback target |
| pend_val | output | AW | Deferred writeback value |

## Verification
The bench uses a block size of ten and then nineteen, both sizes that are not a power of two. At these sizes a mask taken as block-size minus one, or a compare with greater-than in place of greater-or-equal, gives wrong wrapped values.

It steps the masked bits through every position in the buffer in both directions, so it reaches the exact top and bottom wrap points. A design that wraps one step early or late, or that lets a borrow reach the upper bits, gives a wrong new value or changed upper bits.

Directed cases cover the following:
- A pre-subtract from zero, where the result must wrap modulo 2^AW.
- A block-size write in the same cycle as a request, where the old size must still apply.
- Codes with no source, which must never write back.
- Deferred updates, which must never appear on the immediate port.

// File: rtl/agen_pkg.sv
package agen_pkg;

    localparam int MODE_W = 5;

    // step source, decoded from the upper two bits of the modify code
    typedef enum logic [1:0] {
        SRC_DISP = 2'd0,
        SRC_IDX0 = 2'd1,
        SRC_IDX1 = 2'd2,
        SRC_NONE = 2'd3
    } src_e;

    // operation, decoded from the lower three bits of the modify code
    typedef enum logic [2:0] {
        OP_ADD_PEEK = 3'd0,
        OP_SUB_PEEK = 3'd1,
        OP_PRE_ADD  = 3'd2,
        OP_PRE_SUB  = 3'd3,
        OP_POST_ADD = 3'd4,
        OP_POST_SUB = 3'd5,
        OP_CIRC_ADD = 3'd6,
        OP_CIRC_SUB = 3'd7
    } op_e;

endpackage

// File: rtl/agen_step_mux.sv
module agen_step_mux
    import agen_pkg::*;
#(
    parameter int AW     = 32,
    parameter int DISP_W = 8
) (
    input  src_e              src,
    input  logic              unit_step,
    input  logic [DISP_W-1:0] disp,
    input  logic [AW-1:0]     idx0,
    input  logic [AW-1:0]     idx1,
    output logic [AW-1:0]     step
);
    localparam int PAD_W = AW - DISP_W;

    logic [AW-1:0] disp_ext;
    assign disp_ext = {{PAD_W{1'b0}}, disp};

    always_comb begin
        unique case (src)
            SRC_DISP: step = unit_step ? AW'(1) : disp_ext;
            SRC_IDX0: step = idx0;
            SRC_IDX1: step = idx1;
            SRC_NONE: step = '0;
            default:  step = '0;
        endcase
    end
endmodule

// File: rtl/agen_blk_mask.sv
module agen_blk_mask #(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          blk_we,
    input  logic [AW-1:0] blk_wdata,
    output logic [AW-1:0] blk_q,
    output logic [AW-1:0] mask_q
);
    // ones from bit 0 through the highest set bit of v
    function automatic logic [AW-1:0] smear(input logic [AW-1:0] v);
        logic [AW-1:0] m;
        m[AW-1] = v[AW-1];
        for (int i = AW - 2; i >= 0; i--) begin
            m[i] = m[i+1] | v[i];
        end
        return m;
    endfunction

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            blk_q  <= '0;
            mask_q <= '0;
        end else if (blk_we) begin
            blk_q  <= blk_wdata;
            mask_q <= smear(blk_wdata);
        end
    end

    logic [AW:0] mask_inc;
    assign mask_inc = {1'b0, mask_q} + 1'b1;

    assert_mask_pow2_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(mask_inc) == 1);
    assert_mask_span_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (blk_q != '0) |-> (mask_q >= blk_q) && ((mask_q >> 1) < blk_q));
    assert_mask_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (blk_q == '0) |-> (mask_q == '0));
endmodule

// File: rtl/agen_modify_unit.sv
module agen_modify_unit
    import agen_pkg::*;
#(
    parameter int AW = 32
) (
    input  op_e           op,
    input  logic          has_src,
    input  logic [AW-1:0] ar,
    input  logic [AW-1:0] step,
    input  logic [AW-1:0] blk,
    input  logic [AW-1:0] mask,
    output logic [AW-1:0] ea,
    output logic [AW-1:0] new_val,
    output logic          upd
);
    logic [AW-1:0] plus_v, minus_v, low_v;
    logic [AW:0]   up_t, dn_t;
    logic [AW-1:0] up_wrap, dn_wrap, circ_up, circ_dn;

    assign plus_v  = ar + step;
    assign minus_v = ar - step;
    assign low_v   = ar & mask;

    assign up_t = {1'b0, low_v} + {1'b0, step};
    assign dn_t = {1'b0, low_v} - {1'b0, step};

    always_comb begin
        if (up_t >= {1'b0, blk}) up_wrap = up_t[AW-1:0] - blk;
        else                     up_wrap = up_t[AW-1:0];
        if (dn_t[AW])            dn_wrap = dn_t[AW-1:0] + blk;
        else                     dn_wrap = dn_t[AW-1:0];
    end

    assign circ_up = (ar & ~mask) | (up_wrap & mask);
    assign circ_dn = (ar & ~mask) | (dn_wrap & mask);

    always_comb begin
        ea      = ar;
        new_val = ar;
        upd     = 1'b0;
        if (has_src) begin
            unique case (op)
                OP_ADD_PEEK: ea = plus_v;
                OP_SUB_PEEK: ea = minus_v;
                OP_PRE_ADD:  begin ea = plus_v;  new_val = plus_v;  upd = 1'b1; end
                OP_PRE_SUB:  begin ea = minus_v; new_val = minus_v; upd = 1'b1; end
                OP_POST_ADD: begin new_val = plus_v;  upd = 1'b1; end
                OP_POST_SUB: begin new_val = minus_v; upd = 1'b1; end
                OP_CIRC_ADD: begin new_val = circ_up; upd = 1'b1; end
                OP_CIRC_SUB: begin new_val = circ_dn; upd = 1'b1; end
                default:     ea = ar;
            endcase
        end
    end
endmodule

// File: rtl/agen_indirect.sv
module agen_indirect
    import agen_pkg::*;
#(
    parameter int AW     = 32,
    parameter int DISP_W = 8,
    parameter int RIDX_W = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                blk_we,
    input  logic [AW-1:0]       blk_wdata,
    input  logic                op_valid,
    input  logic [MODE_W-1:0]   mod_code,
    input  logic                unit_step,
    input  logic                defer,
    input  logic [RIDX_W-1:0]   ar_idx,
    input  logic [AW-1:0]       ar_val,
    input  logic [DISP_W-1:0]   disp,
    input  logic [AW-1:0]       idx0,
    input  logic [AW-1:0]       idx1,
    output logic                ea_valid,
    output logic [AW-1:0]       ea,
    output logic                wb_en,
    output logic [RIDX_W-1:0]   wb_idx,
    output logic [AW-1:0]       wb_val,
    output logic                pend_en,
    output logic [RIDX_W-1:0]   pend_idx,
    output logic [AW-1:0]       pend_val
);
    src_e          src;
    op_e           op;
    logic [AW-1:0] step, blk, mask, ea_c, new_c;
    logic          upd_c;

    // decode of the modify code
    always_comb begin
        op = op_e'(mod_code[2:0]);
        unique case (mod_code[4:3])
            2'b00:   src = SRC_DISP;
            2'b01:   src = SRC_IDX0;
            2'b10:   src = SRC_IDX1;
            2'b11:   src = SRC_NONE;
            default: src = SRC_NONE;
        endcase
    end

    agen_step_mux #(.AW(AW), .DISP_W(DISP_W)) step_i (
        .src(src), .unit_step(unit_step), .disp(disp),
        .idx0(idx0), .idx1(idx1), .step(step)
    );

    agen_blk_mask #(.AW(AW)) blk_i (
        .clk(clk), .rst_n(rst_n), .blk_we(blk_we), .blk_wdata(blk_wdata),
        .blk_q(blk), .mask_q(mask)
    );

    agen_modify_unit #(.AW(AW)) mod_i (
        .op(op), .has_src(src != SRC_NONE), .ar(ar_val), .step(step),
        .blk(blk), .mask(mask), .ea(ea_c), .new_val(new_c), .upd(upd_c)
    );

    logic              valid_q, wb_q, pend_q;
    logic [AW-1:0]     ea_q, val_q;
    logic [RIDX_W-1:0] idx_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid_q <= 1'b0;
            wb_q    <= 1'b0;
            pend_q  <= 1'b0;
            ea_q    <= '0;
            val_q   <= '0;
            idx_q   <= '0;
        end else begin
            valid_q <= op_valid;
            wb_q    <= op_valid && upd_c && !defer;
            pend_q  <= op_valid && upd_c && defer;
            if (op_valid) begin
                ea_q  <= ea_c;
                val_q <= new_c;
                idx_q <= ar_idx;
            end
        end
    end

    always_comb begin
        ea_valid = valid_q;
        ea       = ea_q;
        wb_en    = wb_q;
        wb_idx   = idx_q;
        wb_val   = val_q;
        pend_en  = pend_q;
        pend_idx = idx_q;
        pend_val = val_q;
    end

    logic is_post, is_pre, is_circ, is_circ_add;
    assign is_post     = (src != SRC_NONE) && (op == OP_POST_ADD || op == OP_POST_SUB);
    assign is_pre      = (src != SRC_NONE) && (op == OP_PRE_ADD || op == OP_PRE_SUB);
    assign is_circ     = (src != SRC_NONE) && (op == OP_CIRC_ADD || op == OP_CIRC_SUB);
    assign is_circ_add = (src != SRC_NONE) && (op == OP_CIRC_ADD);

    assert_post_ea_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && is_post) |=> (ea == $past(ar_val)));
    assert_pre_match_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && is_pre) |=> (ea == wb_val));
    assert_circ_upper_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && is_circ) |=>
            ((wb_val & ~$past(mask)) == ($past(ar_val) & ~$past(mask))) && (ea == $past(ar_val)));
    assert_circ_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && is_circ_add && blk != '0 && (ar_val & mask) < blk && step < blk) |=>
            ((wb_val & $past(mask)) < $past(blk)));
    assert_no_source_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && src == SRC_NONE) |=> (!wb_en && !pend_en && ea == $past(ar_val)));
    assert_defer_route_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && defer) |=> !wb_en);
    assert_one_port_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({wb_en, pend_en}));
    assert_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid |=> (!ea_valid && !wb_en && !pend_en));
endmodule

// File: tb/agen_indirect_tb.sv
`timescale 1ns/1ps
module agen_indirect_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        blk_we = 1'b0;
    logic [31:0] blk_wdata = '0;
    logic        op_valid = 1'b0;
    logic [4:0]  mod_code = '0;
    logic        unit_step = 1'b0;
    logic        defer = 1'b0;
    logic [2:0]  ar_idx = '0;
    logic [31:0] ar_val = '0;
    logic [7:0]  disp = 8'd5;
    logic [31:0] idx0 = 32'h100;
    logic [31:0] idx1 = 32'h20;
    logic        ea_valid, wb_en, pend_en;
    logic [31:0] ea, wb_val, pend_val;
    logic [2:0]  wb_idx, pend_idx;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    agen_indirect dut_i (
        .clk(clk), .rst_n(rst_n), .blk_we(blk_we), .blk_wdata(blk_wdata),
        .op_valid(op_valid), .mod_code(mod_code), .unit_step(unit_step),
        .defer(defer), .ar_idx(ar_idx), .ar_val(ar_val), .disp(disp),
        .idx0(idx0), .idx1(idx1), .ea_valid(ea_valid), .ea(ea),
        .wb_en(wb_en), .wb_idx(wb_idx), .wb_val(wb_val),
        .pend_en(pend_en), .pend_idx(pend_idx), .pend_val(pend_val)
    );

    task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", rq, act, exp);
        end
    endtask

    // present one request at a falling edge; result is registered at the next rising edge
    task automatic run_op(input logic [4:0] code, input logic u, input logic d,
                          input logic [31:0] ar);
        mod_code  = code;
        unit_step = u;
        defer     = d;
        ar_val    = ar;
        op_valid  = 1'b1;
        @(negedge clk);
        op_valid  = 1'b0;
    endtask

    task automatic set_blk(input logic [31:0] v);
        blk_we    = 1'b1;
        blk_wdata = v;
        @(negedge clk);
        blk_we    = 1'b0;
    endtask

    // modulo reference, independent of the design's structure
    function automatic logic [31:0] ref_circ(input logic [31:0] ar, input logic [31:0] stp,
                                             input logic [31:0] bs, input bit sub);
        logic [31:0] msk = '0;
        longint t;
        for (int b = 0; b < 32; b++)
            if (bs[b]) msk = (b == 31) ? 32'hFFFF_FFFF : ((32'h1 << (b + 1)) - 32'h1);
        t = longint'(ar & msk);
        if (sub) begin
            t = t - longint'(stp);
            if (t < 0) t = t + longint'(bs);
        end else begin
            t = t + longint'(stp);
            if (t >= longint'(bs)) t = t - longint'(bs);
        end
        return (ar & ~msk) | (32'(t) & msk);
    endfunction

    typedef struct packed {
        logic [4:0]  code;
        logic        u;
        logic        d;
        logic [31:0] ar;
        logic [31:0] ea;
        logic [1:0]  ports;   // {wb_en, pend_en}
        logic [31:0] nv;
    } vec_t;

    localparam int NV = 14;
    // block size 10 (mask 0xF), disp 5, idx0 0x100, idx1 0x20
    localparam vec_t VECS [NV] = '{
        '{5'b00000, 1'b0, 1'b0, 32'h0000_1000, 32'h0000_1005, 2'b00, 32'h0},          // R2 R1
        '{5'b00001, 1'b0, 1'b0, 32'h0000_1000, 32'h0000_0FFB, 2'b00, 32'h0},          // R2
        '{5'b00010, 1'b1, 1'b0, 32'h0000_1000, 32'h0000_1001, 2'b10, 32'h0000_1001},  // R3 R1 unit step
        '{5'b00011, 1'b0, 1'b0, 32'h0000_0000, 32'hFFFF_FFFB, 2'b10, 32'hFFFF_FFFB},  // R3 wrap
        '{5'b01100, 1'b0, 1'b0, 32'h0000_2000, 32'h0000_2000, 2'b10, 32'h0000_2100},  // R4 idx0
        '{5'b10101, 1'b0, 1'b1, 32'h0000_2000, 32'h0000_2000, 2'b01, 32'h0000_1FE0},  // R4 R10 idx1
        '{5'b00110, 1'b0, 1'b0, 32'hABCD_0008, 32'hABCD_0008, 2'b10, 32'hABCD_0003},  // R5 R7
        '{5'b00111, 1'b0, 1'b0, 32'hABCD_0002, 32'hABCD_0002, 2'b10, 32'hABCD_0007},  // R6 R7
        '{5'b11000, 1'b0, 1'b0, 32'h0000_1234, 32'h0000_1234, 2'b00, 32'h0},          // R9
        '{5'b11101, 1'b0, 1'b1, 32'h0000_0055, 32'h0000_0055, 2'b00, 32'h0},          // R9
        '{5'b00110, 1'b1, 1'b0, 32'h0000_FF09, 32'h0000_FF09, 2'b10, 32'h0000_FF00},  // R5 top edge
        '{5'b00111, 1'b1, 1'b0, 32'h7777_0000, 32'h7777_0000, 2'b10, 32'h7777_0009},  // R6 bottom edge
        '{5'b01001, 1'b0, 1'b0, 32'h0000_0300, 32'h0000_0200, 2'b00, 32'h0},          // R2 R1 idx0
        '{5'b00110, 1'b0, 1'b1, 32'h1000_0004, 32'h1000_0004, 2'b01, 32'h1000_0009}   // R10 R5
    };

    initial begin
        #(200000 * 4);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        ar_idx = 3'd5;
        repeat (3) @(negedge clk);
        // R11 reset state
        chk("R11 reset ea_valid", {31'b0, ea_valid}, 32'd0);
        chk("R11 reset ports", {30'b0, wb_en, pend_en}, 32'd0);
        chk("R11 reset ea", ea, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        set_blk(32'd10);
        for (int i = 0; i < NV; i++) begin
            run_op(VECS[i].code, VECS[i].u, VECS[i].d, VECS[i].ar);
            chk($sformatf("R11 valid vec%0d", i), {31'b0, ea_valid}, 32'd1);
            chk($sformatf("R1-decode ea vec%0d", i), ea, VECS[i].ea);
            chk($sformatf("R10 ports vec%0d", i), {30'b0, wb_en, pend_en}, {30'b0, VECS[i].ports});
            if (VECS[i].ports == 2'b10) begin
                chk($sformatf("R3 wb_val vec%0d", i), wb_val, VECS[i].nv);
                chk($sformatf("R10 wb_idx vec%0d", i), {29'b0, wb_idx}, 32'd5);
            end
            if (VECS[i].ports == 2'b01) begin
                chk($sformatf("R10 pend_val vec%0d", i), pend_val, VECS[i].nv);
                chk($sformatf("R10 pend_idx vec%0d", i), {29'b0, pend_idx}, 32'd5);
            end
        end

        // R11: idle cycle clears strobes
        @(negedge clk);
        chk("R11 idle ea_valid", {31'b0, ea_valid}, 32'd0);
        chk("R11 idle ports", {30'b0, wb_en, pend_en}, 32'd0);

        // R8: write in the same cycle as a request; old size applies to that request
        blk_we    = 1'b1;
        blk_wdata = 32'd19;
        run_op(5'b00110, 1'b0, 1'b0, 32'h0000_0008);
        blk_we    = 1'b0;
        chk("R8 same-cycle old size", wb_val, 32'h0000_0003);
        run_op(5'b00110, 1'b0, 1'b0, 32'h0000_0008);
        chk("R8 new size next cycle", wb_val, 32'h0000_000D);

        // R5 R6 R7 R8: sweep every buffer slot for size 19 (mask 0x1F)
        for (int s = 0; s < 19; s++) begin
            for (int k = 0; k < 2; k++) begin
                logic [31:0] a;
                logic [31:0] st;
                a  = 32'h5A5A_0000 | 32'(s);
                st = (k == 0) ? 32'd1 : 32'd3;
                disp = 8'd3;
                run_op(5'b00110, (k == 0), 1'b0, a);
                chk($sformatf("R5 sweep add s%0d k%0d", s, k), wb_val, ref_circ(a, st, 32'd19, 1'b0));
                run_op(5'b00111, (k == 0), 1'b0, a);
                chk($sformatf("R6 sweep sub s%0d k%0d", s, k), wb_val, ref_circ(a, st, 32'd19, 1'b1));
                chk($sformatf("R7 sweep ea s%0d k%0d", s, k), ea, a);
            end
        end

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule